// File: doc/BRIEF.md
# Dual-Core Interrupt and NMI Distributor

This block sits between the system's interrupt-producing peripherals and two processor cores. It builds one interrupt vector per core from shared system sources, per-core private sources (message-unit, instruction-cache and cross-trigger lines) and a bank of expansion inputs. Power-policy-unit interrupts and reserved positions are also placed in each vector.

Two watchdog requests are merged into one internal non-maskable source. Two expansion NMI inputs sit beside it. A small register port decides which core receives each of these NMI sources.

The non-secure watchdog reset request is always seen as an interrupt. It becomes a system reset request only while software has set a reset-mask bit. The block also publishes, per line, whether the line may wake a core through its external wakeup controller. It crosses the two cores' event outputs to each other's event inputs.

Top module: `core_irq_router`

## Requirements
- R1: The register port writes on a clock edge with `reg_wr` high. `reg_sel`=0 selects the NMI routing register (8 bits, bits 3:2 always read 0). `reg_sel`=1 selects the reset mask (bit 0 only, other bits read 0). `reg_rdata` shows the selected register. After reset the routing register reads 0x01 and the reset mask reads 0x00.
- R2: The secure watchdog request and the always-on watchdog request are ORed. The result drives `nmi_out[0]` when routing bit 0 is 1, and `nmi_out[1]` when routing bit 1 is 1.
- R3: Expansion NMI input `exp_nmi[j]` drives `nmi_out[0]` when routing bit 4+j is 1, and `nmi_out[1]` when routing bit 6+j is 1. Each NMI output is the OR of all its enabled sources.
- R4: Lines 0 to 12 of both vectors carry, in this order: non-secure watchdog reset request, non-secure watchdog interrupt, always-on timer, timer 0, timer 1, dual timer, message unit 0, message unit 1, crypto engine, then the secure MPC, PPC, MSC and bridge-error combined interrupts.
- R5: Lines 6 and 7 carry bit c of `mu0_irq` and of `mu1_irq`. Line 13 carries `icache_irq[c]`. Lines 28 and 29 carry `cti_irq[2c]` and `cti_irq[2c+1]`. Here c is the core index (0 for `irq_c0`, 1 for `irq_c1`), and no core sees the other core's bits.
- R6: Lines 15 to 20 carry `ppu_irq[5:0]` (system, CPU0, CPU1, debug domain 0, debug domain 1, crypto). Lines 22 to 26 carry `ppu_irq[10:6]` (RAM0 to RAM3, debug).
- R7: Lines 14, 21, 27, 30 and 31 are always 0 in both vectors.
- R8: With `HAS_CRYPTO`=0, lines 8 and 20 are always 0. With `HAS_DBG_PD`=0, lines 18 and 19 are always 0.
- R9: `nmi_wake` is 1. `wake_flags` bits 0 to 12 are 1 and bits 13 to 31 are 0. Bit 32+i equals bit i of parameter `EXP_WAKE`.
- R10: Line 32+i of both vectors equals `exp_irq[i]`.
- R11: `sys_rst_req` equals `wd_ns_rst_req` while reset-mask bit 0 is 1, and is 0 otherwise. Line 0 follows the request in either case.
- R12: `rxev[0]` equals `txev[1]` and `rxev[1]` equals `txev[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: NMI routing register, 1: reset mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of selected register |
| wd_sec_irq | input | 1 | Secure watchdog request |
| wd_aon_irq | input | 1 | Always-on watchdog request |
| wd_ns_rst_req | input | 1 | Non-secure watchdog reset request |
| wd_ns_irq | input | 1 | Non-secure watchdog interrupt |
| tmr_aon_irq | input | 1 | Always-on timer |
| tmr0_irq | input | 1 | Timer 0 |
| tmr1_irq | input | 1 | Timer 1 |
| dtmr_irq | input | 1 | Dual timer |
| mu0_irq | input | 2 | Message unit 0, one bit per core |
| mu1_irq | input | 2 | Message unit 1, one bit per core |
| crypto_irq | input | 1 | Crypto engine |
| mpc_irq | input | 1 | Secure MPC combined |
| ppc_irq | input | 1 | Secure PPC combined |
| msc_irq | input | 1 | Secure MSC combined |
| bridge_irq | input | 1 | Secure bridge-error combined |
| icache_irq | input | 2 | Instruction-cache interrupt, one per core |
| cti_irq | input | 4 | Cross-trigger interrupts, two per core |
| ppu_irq | input | 11 | Power-policy-unit interrupts |
| exp_irq | input | NUM_EXP | Expansion interrupts |
| exp_nmi | input | 2 | Expansion NMI inputs |
| txev | input | 2 | Outgoing event of each core |
| rxev | output | 2 | Incoming event of each core |
| irq_c0 | output | 32+NUM_EXP | Interrupt vector of core 0 |
| irq_c1 | output | 32+NUM_EXP | Interrupt vector of core 1 |
| nmi_out | output | 2 | NMI of each core |
| wake_flags | output | 32+NUM_EXP | Wake-capable flag per line |
| nmi_wake | output | 1 | NMI wake-capable flag |
| sys_rst_req | output | 1 | System reset request |

## Verification
The assertions hold on every cycle for several properties:
- The reset request stays low whenever the mask bit is clear, and line 0 always mirrors the watchdog reset request.
- Line 13 of each vector follows only that core's cache interrupt.
- No NMI appears without a live NMI source.
- The configuration is stable across cycles with no write.

Only the bench scenarios can show the full mapping. This covers the position of every shared, private and power-policy line, the exact routing of each NMI source to each core, the reserved and absent-option lines staying low while all inputs are high, and the wake pattern including the expansion parameter.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

    localparam int BASE_LINES = 32;
    localparam int NUM_CORES  = 2;
    localparam int NUM_XNMI   = 2;
    localparam int NUM_PPU    = 11;

    // line positions
    localparam int L_NSWD_RST = 0;
    localparam int L_NSWD     = 1;
    localparam int L_TAON     = 2;
    localparam int L_TMR0     = 3;
    localparam int L_TMR1     = 4;
    localparam int L_DTMR     = 5;
    localparam int L_MU0      = 6;
    localparam int L_MU1      = 7;
    localparam int L_CRYPTO   = 8;
    localparam int L_MPC      = 9;
    localparam int L_PPC      = 10;
    localparam int L_MSC      = 11;
    localparam int L_BRIDGE   = 12;
    localparam int L_ICACHE   = 13;
    localparam int L_PPU_LO   = 15;
    localparam int L_PPU_HI   = 22;
    localparam int L_CTI      = 28;

    localparam logic [7:0]  ROUTE_RST   = 8'h01;
    localparam logic [7:0]  ROUTE_WMASK = 8'hF3;
    localparam logic [31:0] BASE_WAKE   = 32'h0000_1FFF;

    typedef struct packed {
        logic [7:0] route;
        logic       nswd_en;
    } cfg_t;

    typedef struct packed {
        logic               wd_ns_rst;
        logic               wd_ns;
        logic               tmr_aon;
        logic               tmr0;
        logic               tmr1;
        logic               dtmr;
        logic               crypto;
        logic               mpc;
        logic               ppc;
        logic               msc;
        logic               bridge;
        logic [NUM_PPU-1:0] ppu;
    } shared_src_t;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_dist_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       sel,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output cfg_t       cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            if (sel) cfg_d.nswd_en = wdata[0];
            else     cfg_d.route   = wdata & ROUTE_WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.route   <= ROUTE_RST;
            cfg_q.nswd_en <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg   = cfg_q;
    assign rdata = sel ? {7'b0, cfg_q.nswd_en} : cfg_q.route;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cfg_q)); // R1
    AST_ROUTE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.route[3:2] == 2'b00); // R1

endmodule

// File: rtl/irq_line_map.sv
module irq_line_map
    import irq_dist_pkg::*;
#(
    parameter int CORE       = 0,
    parameter int NUM_EXP    = 64,
    parameter bit HAS_CRYPTO = 1'b1,
    parameter bit HAS_DBG_PD = 1'b1,
    localparam int NL        = BASE_LINES + NUM_EXP
)(
    input  shared_src_t          src,
    input  logic [1:0]           mu0,
    input  logic [1:0]           mu1,
    input  logic [1:0]           icache,
    input  logic [3:0]           cti,
    input  logic [NUM_EXP-1:0]   exp,
    output logic [NL-1:0]        lines
);

    logic [NUM_PPU-1:0] ppu_avail;

    // absent options force their power-policy lines low
    generate
        if (HAS_CRYPTO && HAS_DBG_PD) begin : g_ppu_full
            assign ppu_avail = src.ppu;
        end else begin : g_ppu_trim
            always_comb begin
                ppu_avail = src.ppu;
                if (!HAS_DBG_PD) ppu_avail[4:3] = 2'b00;
                if (!HAS_CRYPTO) ppu_avail[5]   = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        lines                = '0;
        lines[L_NSWD_RST]    = src.wd_ns_rst;
        lines[L_NSWD]        = src.wd_ns;
        lines[L_TAON]        = src.tmr_aon;
        lines[L_TMR0]        = src.tmr0;
        lines[L_TMR1]        = src.tmr1;
        lines[L_DTMR]        = src.dtmr;
        lines[L_MU0]         = mu0[CORE];
        lines[L_MU1]         = mu1[CORE];
        lines[L_CRYPTO]      = HAS_CRYPTO ? src.crypto : 1'b0;
        lines[L_MPC]         = src.mpc;
        lines[L_PPC]         = src.ppc;
        lines[L_MSC]         = src.msc;
        lines[L_BRIDGE]      = src.bridge;
        lines[L_ICACHE]      = icache[CORE];
        lines[L_PPU_LO +: 6] = ppu_avail[5:0];
        lines[L_PPU_HI +: 5] = ppu_avail[10:6];
        lines[L_CTI]         = cti[2*CORE];
        lines[L_CTI+1]       = cti[2*CORE+1];
        lines[BASE_LINES +: NUM_EXP] = exp;
    end

endmodule

// File: rtl/irq_nmi_steer.sv
module irq_nmi_steer
    import irq_dist_pkg::*;
(
    input  logic                 wd_sec,
    input  logic                 wd_aon,
    input  logic [NUM_XNMI-1:0]  xnmi,
    input  logic [7:0]           route,
    output logic [NUM_CORES-1:0] nmi
);

    logic wd_merged;
    assign wd_merged = wd_sec | wd_aon;

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            assign nmi[c] = (wd_merged & route[c])
                          | (|(xnmi & route[4 + NUM_XNMI*c +: NUM_XNMI]));
        end
    endgenerate

endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
    import irq_dist_pkg::*;
#(
    parameter int                 NUM_EXP    = 64,
    parameter bit                 HAS_CRYPTO = 1'b1,
    parameter bit                 HAS_DBG_PD = 1'b1,
    parameter logic [NUM_EXP-1:0] EXP_WAKE   = '1,
    localparam int                NL         = BASE_LINES + NUM_EXP
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               wd_sec_irq,
    input  logic               wd_aon_irq,
    input  logic               wd_ns_rst_req,
    input  logic               wd_ns_irq,
    input  logic               tmr_aon_irq,
    input  logic               tmr0_irq,
    input  logic               tmr1_irq,
    input  logic               dtmr_irq,
    input  logic [1:0]         mu0_irq,
    input  logic [1:0]         mu1_irq,
    input  logic               crypto_irq,
    input  logic               mpc_irq,
    input  logic               ppc_irq,
    input  logic               msc_irq,
    input  logic               bridge_irq,
    input  logic [1:0]         icache_irq,
    input  logic [3:0]         cti_irq,
    input  logic [10:0]        ppu_irq,
    input  logic [NUM_EXP-1:0] exp_irq,
    input  logic [1:0]         exp_nmi,
    input  logic [1:0]         txev,
    output logic [1:0]         rxev,
    output logic [NL-1:0]      irq_c0,
    output logic [NL-1:0]      irq_c1,
    output logic [1:0]         nmi_out,
    output logic [NL-1:0]      wake_flags,
    output logic               nmi_wake,
    output logic               sys_rst_req
);

    cfg_t        cfg;
    shared_src_t src;
    logic [NL-1:0] vec [NUM_CORES];

    irq_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    always_comb begin
        src.wd_ns_rst = wd_ns_rst_req;
        src.wd_ns     = wd_ns_irq;
        src.tmr_aon   = tmr_aon_irq;
        src.tmr0      = tmr0_irq;
        src.tmr1      = tmr1_irq;
        src.dtmr      = dtmr_irq;
        src.crypto    = crypto_irq;
        src.mpc       = mpc_irq;
        src.ppc       = ppc_irq;
        src.msc       = msc_irq;
        src.bridge    = bridge_irq;
        src.ppu       = ppu_irq;
    end

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_map
            irq_line_map #(
                .CORE       (c),
                .NUM_EXP    (NUM_EXP),
                .HAS_CRYPTO (HAS_CRYPTO),
                .HAS_DBG_PD (HAS_DBG_PD)
            ) u_map (
                .src    (src),
                .mu0    (mu0_irq),
                .mu1    (mu1_irq),
                .icache (icache_irq),
                .cti    (cti_irq),
                .exp    (exp_irq),
                .lines  (vec[c])
            );
        end
    endgenerate

    assign irq_c0 = vec[0];
    assign irq_c1 = vec[1];

    irq_nmi_steer u_nmi (
        .wd_sec (wd_sec_irq),
        .wd_aon (wd_aon_irq),
        .xnmi   (exp_nmi),
        .route  (cfg.route),
        .nmi    (nmi_out)
    );

    assign sys_rst_req = wd_ns_rst_req & cfg.nswd_en;
    assign wake_flags  = {EXP_WAKE, BASE_WAKE};
    assign nmi_wake    = 1'b1;
    assign rxev        = {txev[0], txev[1]};

    AST_RST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.nswd_en |-> !sys_rst_req); // R11
    AST_LINE0_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_c0[0] == wd_ns_rst_req && irq_c1[0] == wd_ns_rst_req); // R11
    AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_out != 2'b00) |-> (wd_sec_irq || wd_aon_irq || exp_nmi != 2'b00)); // R2
    AST_ICACHE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_c0[13] == icache_irq[0] && irq_c1[13] == icache_irq[1]); // R5

endmodule

// File: tb/sim_core_irq_router.sv
`timescale 1ns/1ps
module sim_core_irq_router;

    localparam int NEXP = 64;
    localparam int NL   = 32 + NEXP;
    localparam logic [NEXP-1:0] WAKE_PAT = 64'hA5A5_0F0F_3C3C_F00F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, rdata1;
    logic [12:0] sh = '0;      // bit k feeds the source of shared line k
    logic wd_sec = 0, wd_aon = 0;
    logic [1:0] mu0 = '0, mu1 = '0, icache = '0, xnmi = '0, txev = '0;
    logic [3:0] cti = '0;
    logic [10:0] ppu = '0;
    logic [NEXP-1:0] expi = '0;
    logic [1:0] rxev, nmi, rxev1, nmi1;
    logic [NL-1:0] c0, c1, wake, u1c0, u1c1, wake1;
    logic nmi_wake, rst_req, nmi_wake1, rst_req1;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    core_irq_router #(.NUM_EXP(NEXP), .EXP_WAKE(WAKE_PAT)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wd_sec_irq(wd_sec), .wd_aon_irq(wd_aon), .wd_ns_rst_req(sh[0]),
        .wd_ns_irq(sh[1]), .tmr_aon_irq(sh[2]), .tmr0_irq(sh[3]),
        .tmr1_irq(sh[4]), .dtmr_irq(sh[5]), .mu0_irq(mu0), .mu1_irq(mu1),
        .crypto_irq(sh[8]), .mpc_irq(sh[9]), .ppc_irq(sh[10]), .msc_irq(sh[11]),
        .bridge_irq(sh[12]), .icache_irq(icache), .cti_irq(cti), .ppu_irq(ppu),
        .exp_irq(expi), .exp_nmi(xnmi), .txev(txev), .rxev(rxev),
        .irq_c0(c0), .irq_c1(c1), .nmi_out(nmi), .wake_flags(wake),
        .nmi_wake(nmi_wake), .sys_rst_req(rst_req)
    );

    core_irq_router #(.NUM_EXP(NEXP), .HAS_CRYPTO(1'b0), .HAS_DBG_PD(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rdata1),
        .wd_sec_irq(wd_sec), .wd_aon_irq(wd_aon), .wd_ns_rst_req(sh[0]),
        .wd_ns_irq(sh[1]), .tmr_aon_irq(sh[2]), .tmr0_irq(sh[3]),
        .tmr1_irq(sh[4]), .dtmr_irq(sh[5]), .mu0_irq(mu0), .mu1_irq(mu1),
        .crypto_irq(sh[8]), .mpc_irq(sh[9]), .ppc_irq(sh[10]), .msc_irq(sh[11]),
        .bridge_irq(sh[12]), .icache_irq(icache), .cti_irq(cti), .ppu_irq(ppu),
        .exp_irq(expi), .exp_nmi(xnmi), .txev(txev), .rxev(rxev1),
        .irq_c0(u1c0), .irq_c1(u1c1), .nmi_out(nmi1), .wake_flags(wake1),
        .nmi_wake(nmi_wake1), .sys_rst_req(rst_req1)
    );

    task automatic chk(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        sh = '0; wd_sec = 0; wd_aon = 0; mu0 = '0; mu1 = '0; icache = '0;
        xnmi = '0; txev = '0; cti = '0; ppu = '0; expi = '0;
        #1;
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic reg_read(input logic sel, output logic [7:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_regs();
        logic [7:0] d;
        reg_read(1'b0, d); chk("R1 route reset", NL'(d), NL'(8'h01));
        reg_read(1'b1, d); chk("R1 mask reset", NL'(d), NL'(8'h00));
        reg_write(1'b0, 8'hFF);
        reg_read(1'b0, d); chk("R1 route gap bits", NL'(d), NL'(8'hF3));
        reg_write(1'b1, 8'hFE);
        reg_read(1'b1, d); chk("R1 mask upper bits", NL'(d), NL'(8'h00));
        reg_write(1'b1, 8'h01);
        reg_read(1'b1, d); chk("R1 mask set", NL'(d), NL'(8'h01));
        reg_read(1'b0, d); chk("R1 route kept", NL'(d), NL'(8'hF3));
        reg_write(1'b1, 8'h00);
    endtask

    task automatic t_wd_nmi();
        clear_inputs();
        reg_write(1'b0, 8'h01);
        chk("R2 idle", NL'(nmi), NL'(2'b00));
        wd_sec = 1; #1; chk("R2 secure wd to core0", NL'(nmi), NL'(2'b01));
        wd_sec = 0; wd_aon = 1; #1; chk("R2 aon wd to core0", NL'(nmi), NL'(2'b01));
        reg_write(1'b0, 8'h02); chk("R2 wd to core1", NL'(nmi), NL'(2'b10));
        reg_write(1'b0, 8'h03); chk("R2 wd to both", NL'(nmi), NL'(2'b11));
        reg_write(1'b0, 8'h00); chk("R2 wd disabled", NL'(nmi), NL'(2'b00));
        clear_inputs();
    endtask

    task automatic t_exp_nmi();
        clear_inputs();
        reg_write(1'b0, 8'h10);
        xnmi = 2'b01; #1; chk("R3 xnmi0 core0", NL'(nmi), NL'(2'b01));
        xnmi = 2'b10; #1; chk("R3 xnmi1 not enabled", NL'(nmi), NL'(2'b00));
        reg_write(1'b0, 8'h80); chk("R3 xnmi1 core1", NL'(nmi), NL'(2'b10));
        reg_write(1'b0, 8'h40);
        xnmi = 2'b01; #1; chk("R3 xnmi0 core1", NL'(nmi), NL'(2'b10));
        reg_write(1'b0, 8'h21);
        xnmi = 2'b10; #1; chk("R3 xnmi1 core0", NL'(nmi), NL'(2'b01));
        wd_sec = 1; xnmi = 2'b00; #1; chk("R3 OR with wd", NL'(nmi), NL'(2'b01));
        reg_write(1'b0, 8'h01);
        clear_inputs();
    endtask

    task automatic t_shared();
        for (int k = 0; k < 13; k++) begin
            clear_inputs();
            if (k == 6) mu0 = 2'b11;
            else if (k == 7) mu1 = 2'b11;
            else sh[k] = 1'b1;
            #1;
            chk($sformatf("R4 line %0d core0", k), c0, NL'(1) << k);
            chk($sformatf("R4 line %0d core1", k), c1, NL'(1) << k);
        end
        clear_inputs();
    endtask

    task automatic t_private();
        clear_inputs();
        mu0 = 2'b01; #1;
        chk("R5 mu0 core0", c0, NL'(1) << 6); chk("R5 mu0 core1 silent", c1, '0);
        mu0 = 2'b10; mu1 = 2'b01; #1;
        chk("R5 mu split core0", c0, NL'(1) << 7); chk("R5 mu split core1", c1, NL'(1) << 6);
        clear_inputs();
        icache = 2'b10; #1;
        chk("R5 icache core0 silent", c0, '0); chk("R5 icache core1", c1, NL'(1) << 13);
        clear_inputs();
        cti = 4'b0010; #1;
        chk("R5 cti1 core0", c0, NL'(1) << 29); chk("R5 cti1 core1 silent", c1, '0);
        cti = 4'b0100; #1;
        chk("R5 cti2 core0 silent", c0, '0); chk("R5 cti2 core1", c1, NL'(1) << 28);
        clear_inputs();
    endtask

    task automatic t_ppu();
        for (int p = 0; p < 11; p++) begin
            clear_inputs();
            ppu[p] = 1'b1; #1;
            chk($sformatf("R6 ppu %0d", p), c0, NL'(1) << (p < 6 ? 15 + p : 16 + p));
            chk($sformatf("R6 ppu %0d core1", p), c1, NL'(1) << (p < 6 ? 15 + p : 16 + p));
        end
        clear_inputs();
    endtask

    task automatic t_reserved();
        logic [NL-1:0] rmask;
        rmask = (NL'(1) << 14) | (NL'(1) << 21) | (NL'(1) << 27) | (NL'(1) << 30) | (NL'(1) << 31);
        sh = '1; mu0 = '1; mu1 = '1; icache = '1; cti = '1; ppu = '1; expi = '1; #1;
        chk("R7 reserved core0", c0 & rmask, '0);
        chk("R7 reserved core1", c1 & rmask, '0);
        chk("R7 all else high core0", c0 | rmask, '1);
        // R8: option-less instance keeps its optional lines low
        chk("R8 crypto absent", u1c0 & ((NL'(1) << 8) | (NL'(1) << 20)), '0);
        chk("R8 dbg pd absent", u1c1 & ((NL'(1) << 18) | (NL'(1) << 19)), '0);
        chk("R8 present lines", c0 & NL'(32'h001C_0100), NL'(32'h001C_0100));
        clear_inputs();
    endtask

    task automatic t_wake();
        chk("R9 wake flags", wake, {WAKE_PAT, 32'h0000_1FFF});
        chk("R9 nmi wake", NL'(nmi_wake), NL'(1));
    endtask

    task automatic t_expansion();
        clear_inputs();
        expi = 64'hDEAD_BEEF_0123_4567; #1;
        chk("R10 exp core0", c0, {64'hDEAD_BEEF_0123_4567, 32'h0});
        chk("R10 exp core1", c1, {64'hDEAD_BEEF_0123_4567, 32'h0});
        clear_inputs();
    endtask

    task automatic t_rstgate();
        clear_inputs();
        reg_write(1'b1, 8'h00);
        sh[0] = 1; #1;
        chk("R11 masked", NL'(rst_req), NL'(0));
        chk("R11 line0 while masked", NL'(c0[0]), NL'(1));
        reg_write(1'b1, 8'h01);
        chk("R11 enabled", NL'(rst_req), NL'(1));
        sh[0] = 0; #1;
        chk("R11 request drop", NL'(rst_req), NL'(0));
        reg_write(1'b1, 8'h00);
        clear_inputs();
    endtask

    task automatic t_events();
        txev = 2'b01; #1; chk("R12 core0 to core1", NL'(rxev), NL'(2'b10));
        txev = 2'b10; #1; chk("R12 core1 to core0", NL'(rxev), NL'(2'b01));
        txev = 2'b00; #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_regs();
        t_wd_nmi();
        t_exp_nmi();
        t_shared();
        t_private();
        t_ppu();
        t_reserved();
        t_wake();
        t_expansion();
        t_rstgate();
        t_events();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule